// File: doc/BRIEF.md
# Serial Control Register Writer

This block is a write-only two-wire (I2C) slave that loads a bank of ten 8-bit control registers for an audio processing path. SCL and SDA are sampled with the system clock, passed through a two-flop synchronizer and a glitch filter, and then examined for START and STOP conditions. After a START, the block expects the fixed address byte 0x80. Next comes a subaddress byte, then any number of data bytes, up to STOP.

Bit 7 of the subaddress chooses the write pattern. When it is clear, every data byte lands in the one selected register. When it is set, a 4-bit pointer steps forward after each byte and wraps from 15 to 0. Bytes whose pointer value is 10 to 15 are acknowledged but discarded.

Each register drives a parallel output slice: slice k is `regs_o[8k+7:8k]`. The registers hold, in index order: input attenuation, surround/output/effect, phase resistor, bass, middle/treble, left speaker attenuation, right speaker attenuation, left aux attenuation, right aux attenuation, input select/aux-out source.

Top module: `serial_ctrl_regs`

## Requirements
- R1: While `rst` is high, the registers take these values on each clock edge: 0x3F at index 0 (maximum input attenuation), 0x02 at index 1 (surround mode field bits 1:0 = 2, off), 0x00 at index 2, 0x17 at index 3, 0x77 at index 4, 0x78 at indices 5 to 8 (mute code), and 0x06 at index 9 (input 1 selected).
- R2: The block acknowledges an accepted byte by asserting `sda_pull_o` during the ninth SCL pulse, so the bus reads 0 while SCL is high. It releases the line after that pulse. It raises the pull only while SCL is low.
- R3: Bytes are received most significant bit first. Only the address byte 0x80 (7-bit address 0x40, write bit 0) is accepted.
- R4: After any other address byte, the block gives no acknowledge, reads SDA as 1 on every later ninth pulse, and writes nothing until the next START.
- R5: In the subaddress byte, bit 7 is the increment flag, bits 6:4 have no effect, and bits 3:0 give the starting register index.
- R6: With the increment flag clear, every data byte up to STOP is written to the selected register, so the last byte sent is the one kept.
- R7: With the increment flag set, data byte n goes to index (start + n) mod 16. The pointer wraps from 15 to 0.
- R8: A data byte aimed at index 10 to 15 changes no register but is still acknowledged.
- R9: A level on SCL or SDA that lasts fewer than `FILT_LEN` clocks is ignored.
- R10: A START that arrives partway through a byte discards that byte and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired-AND level) |
| sda_pull_o | output | 1 | High drives SDA low (acknowledge) |
| regs_o | output | 8*NUM_REGS | All registers side by side; register k in bits 8k+7:8k |

## Verification
The hardest cases to reach from the ports are the misaligned ones. One is a repeated START after only four data bits. Another is an SDA glitch that lands while SCL is high, where an unfiltered design would see a false START and STOP. The bench drives both at bit level through its wired-AND bus model, then sends a full write and checks that the register bank contains only the data that follows the restart. Wrap-around and the discarded indices are reached by starting an incrementing write at index 8 or 14. Every register is then compared, so a stray write anywhere shows up.

// File: rtl/scr_pkg.sv
package scr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_DATA,
    ST_IGNORE
  } rx_state_e;

  function automatic logic [7:0] reg_default(input int idx);
    case (idx)
      0:       return 8'h3F;
      1:       return 8'h02;
      2:       return 8'h00;
      3:       return 8'h17;
      4:       return 8'h77;
      5, 6, 7, 8: return 8'h78;
      9:       return 8'h06;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/scr_glitch_filter.sv
module scr_glitch_filter #(
  parameter int   FILT_LEN = 3,
  parameter logic INIT     = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= {2{INIT}};
      clean  <= INIT;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], raw};
      if (sync_q[1] == clean) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        clean <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R9: the filtered level only moves to a value the synchronizer held
  a_r9_follows_sync: assert property (@(posedge clk) disable iff (rst)
    (clean != $past(clean)) |-> (clean == $past(sync_q[1])));

endmodule

// File: rtl/scr_bus_events.sv
module scr_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl;
      sda_d <= sda;
    end
  end

  always_comb begin
    scl_rise = scl & ~scl_d;
    scl_fall = ~scl & scl_d;
    start_ev = scl & scl_d & sda_d & ~sda;
    stop_ev  = scl & scl_d & ~sda_d & sda;
  end

endmodule

// File: rtl/scr_rx_engine.sv
module scr_rx_engine
  import scr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h40,
  parameter int         NUM_REGS = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_lvl,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  output logic       sda_low,
  output logic       wr_en,
  output logic [3:0] wr_idx,
  output logic [7:0] wr_data
);
  localparam logic [7:0] ADDR_BYTE = {DEV_ADDR, 1'b0};
  localparam logic [4:0] IDX_LIMIT = 5'(NUM_REGS);

  rx_state_e  state;
  logic [7:0] shreg;
  logic [3:0] bit_cnt;
  logic       ack_ph;
  logic       inc_q;
  logic [3:0] ptr;
  logic       byte_done;

  assign byte_done = scl_fall && !ack_ph && (bit_cnt == 4'd8);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      bit_cnt <= '0;
      ack_ph  <= 1'b0;
      inc_q   <= 1'b0;
      ptr     <= '0;
      sda_low <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_ev || start_ev) begin
        state   <= stop_ev ? ST_IDLE : ST_ADDR;
        sda_low <= 1'b0;
        ack_ph  <= 1'b0;
        bit_cnt <= '0;
      end else if (state != ST_IDLE && state != ST_IGNORE) begin
        if (scl_rise && !ack_ph && bit_cnt < 4'd8) begin
          shreg   <= {shreg[6:0], sda_lvl};
          bit_cnt <= bit_cnt + 1'b1;
        end else if (scl_fall && ack_ph) begin
          ack_ph  <= 1'b0;
          sda_low <= 1'b0;
          bit_cnt <= '0;
        end else if (byte_done) begin
          ack_ph <= 1'b1;
          unique case (state)
            ST_ADDR: begin
              if (shreg == ADDR_BYTE) begin
                sda_low <= 1'b1;
                state   <= ST_SUB;
              end else begin
                state <= ST_IGNORE;
              end
            end
            ST_SUB: begin
              sda_low <= 1'b1;
              inc_q   <= shreg[7];
              ptr     <= shreg[3:0];
              state   <= ST_DATA;
            end
            ST_DATA: begin
              sda_low <= 1'b1;
              if ({1'b0, ptr} < IDX_LIMIT) begin
                wr_en   <= 1'b1;
                wr_idx  <= ptr;
                wr_data <= shreg;
              end
              if (inc_q) ptr <= ptr + 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R2: acknowledge pull starts only while SCL is low
  a_r2_pull_on_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_low) |-> !scl_lvl);

  // R4: an ignored transfer never drives the line
  a_r4_silent_ignore: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE) |-> !sda_low);

  // R7: in increment mode the pointer steps by one per data byte, wrapping
  a_r7_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (byte_done && state == ST_DATA && inc_q && !start_ev && !stop_ev)
      |=> (ptr == $past(ptr) + 4'd1));

endmodule

// File: rtl/serial_ctrl_regs.sv
module serial_ctrl_regs
  import scr_pkg::*;
#(
  parameter int         FILT_LEN = 3,
  parameter logic [6:0] DEV_ADDR = 7'h40,
  parameter int         NUM_REGS = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull_o,
  output logic [8*NUM_REGS-1:0] regs_o
);
  logic       scl_f, sda_f;
  logic       scl_rise, scl_fall, start_ev, stop_ev;
  logic       wr_en;
  logic [3:0] wr_idx;
  logic [7:0] wr_data;
  logic [7:0] regs_q [NUM_REGS];

  scr_glitch_filter #(.FILT_LEN(FILT_LEN), .INIT(1'b1)) u_scl_filt (
    .clk(clk), .rst(rst), .raw(scl_i), .clean(scl_f));

  scr_glitch_filter #(.FILT_LEN(FILT_LEN), .INIT(1'b1)) u_sda_filt (
    .clk(clk), .rst(rst), .raw(sda_i), .clean(sda_f));

  scr_bus_events u_events (
    .clk(clk), .rst(rst), .scl(scl_f), .sda(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev));

  scr_rx_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_engine (
    .clk(clk), .rst(rst), .scl_lvl(scl_f), .sda_lvl(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .sda_low(sda_pull_o), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs_q[g] <= reg_default(g);
      else if (wr_en && wr_idx == 4'(g))
        regs_q[g] <= wr_data;
    end
    assign regs_o[8*g +: 8] = regs_q[g];

    // R1: every register holds its defined value after reset
    a_r1_reset_value: assert property (@(posedge clk)
      rst |=> (regs_q[g] == reg_default(g)));
  end

  // R8: a write strobe never targets an index outside the bank
  a_r8_write_in_range: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (32'(wr_idx) < NUM_REGS));

endmodule

// File: tb/serial_ctrl_regs_test.sv
module serial_ctrl_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam int NR = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic sda_line;
  logic [8*NR-1:0] regs;
  logic ack_strobe = 1'b0;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] model [NR];
  logic  ack_q [$];
  string tag_q [$];

  assign sda_line = sda_m & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_ctrl_regs uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .regs_o(regs));

  // monitor: pops the expected acknowledge level and compares
  always @(posedge ack_strobe) begin
    logic  e;
    string t;
    e = ack_q.pop_front();
    t = tag_q.pop_front();
    n_tests++;
    if (sda_line !== e) begin
      n_fail++;
      $display("FAIL %s: ack level actual %b expected %b", t, sda_line, e);
    end
  end

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait(); qwait();
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    sda_m = b; qwait();
    scl_m = 1'b1; qwait();
    if (glitch) begin
      sda_m = 1'b0; @(negedge clk);
      sda_m = b;
    end
    qwait();
    scl_m = 1'b0; qwait();
  endtask

  // driver: sends a byte and pushes the expected acknowledge level
  task automatic send_byte(input logic [7:0] b, input logic exp_ack,
                           input string tag, input bit glitch_msb = 1'b0);
    for (int i = 7; i >= 0; i--) send_bit(b[i], glitch_msb && i == 7);
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    ack_q.push_back(exp_ack);
    tag_q.push_back(tag);
    ack_strobe = 1'b1; @(negedge clk);
    ack_strobe = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic check_regs(input string tag);
    qwait();
    for (int i = 0; i < NR; i++) begin
      n_tests++;
      if (regs[8*i +: 8] !== model[i]) begin
        n_fail++;
        $display("FAIL %s: reg %0d actual %h expected %h", tag, i, regs[8*i +: 8], model[i]);
      end
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL all: watchdog expired, actual running expected finished");
      finish_run();
    end
  end

  initial begin
    model[0] = 8'h3F; model[1] = 8'h02; model[2] = 8'h00; model[3] = 8'h17;
    model[4] = 8'h77; model[5] = 8'h78; model[6] = 8'h78; model[7] = 8'h78;
    model[8] = 8'h78; model[9] = 8'h06;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    check_regs("R1");

    // R6 single-register writes, last byte kept; R3 address accepted
    bus_start();
    send_byte(8'h80, 1'b0, "R3");
    send_byte(8'h03, 1'b0, "R2");
    send_byte(8'h11, 1'b0, "R6");
    send_byte(8'h22, 1'b0, "R6");
    bus_stop();
    model[3] = 8'h22;
    check_regs("R6");

    // R8 increment across the top of the bank; dropped bytes still acked
    bus_start();
    send_byte(8'h80, 1'b0, "R2");
    send_byte(8'h88, 1'b0, "R5");
    send_byte(8'hA1, 1'b0, "R7");
    send_byte(8'hB2, 1'b0, "R7");
    send_byte(8'hC3, 1'b0, "R8");
    send_byte(8'hD4, 1'b0, "R8");
    bus_stop();
    model[8] = 8'hA1; model[9] = 8'hB2;
    check_regs("R8");

    // R7 pointer wraps 15 -> 0
    bus_start();
    send_byte(8'h80, 1'b0, "R2");
    send_byte(8'h8E, 1'b0, "R5");
    send_byte(8'h01, 1'b0, "R8");
    send_byte(8'h02, 1'b0, "R8");
    send_byte(8'h5A, 1'b0, "R7");
    send_byte(8'h6B, 1'b0, "R7");
    bus_stop();
    model[0] = 8'h5A; model[1] = 8'h6B;
    check_regs("R7");

    // R4 wrong address: no ack, no writes
    bus_start();
    send_byte(8'h82, 1'b1, "R4");
    send_byte(8'h05, 1'b1, "R4");
    send_byte(8'h99, 1'b1, "R4");
    bus_stop();
    check_regs("R4");

    // R5 bits 6:4 of the subaddress have no effect
    bus_start();
    send_byte(8'h80, 1'b0, "R3");
    send_byte(8'h74, 1'b0, "R5");
    send_byte(8'h3C, 1'b0, "R5");
    send_byte(8'h4D, 1'b0, "R6");
    bus_stop();
    model[4] = 8'h4D;
    check_regs("R5");

    // R9 a one-clock SDA dip while SCL is high is not a START
    bus_start();
    send_byte(8'h80, 1'b0, "R2");
    send_byte(8'h02, 1'b0, "R5");
    send_byte(8'hFF, 1'b0, "R9", 1'b1);
    bus_stop();
    model[2] = 8'hFF;
    check_regs("R9");

    // R10 repeated START after four bits restarts address reception
    bus_start();
    send_byte(8'h80, 1'b0, "R2");
    send_byte(8'h06, 1'b0, "R5");
    send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0);
    bus_start();
    send_byte(8'h80, 1'b0, "R10");
    send_byte(8'h06, 1'b0, "R10");
    send_byte(8'h3E, 1'b0, "R10");
    bus_stop();
    model[6] = 8'h3E;
    check_regs("R10");

    done = 1'b1;
    finish_run();
  end

endmodule